// File: doc/BRIEF.md
# Host Command and Interrupt Status Controller

This unit sits between a host bus and the datapath of a network controller. The host writes 16-bit command words. The upper five bits of each word select an operation and the lower eleven bits carry its argument. Every control action goes through this one port: choosing the register window, acknowledging events, loading the interrupt enable mask and the status read mask, requesting a software interrupt, and enabling, disabling or resetting the receive and transmit paths. The host reads one 16-bit status word. That word reports the selected window, a busy flag and the eight latched event bits after the read mask is applied.

The datapath sends one-cycle pulses on seven event inputs. The unit latches these pulses and drives one interrupt request line. A small sequencer runs the busy flag. It moves from ST_IDLE to ST_CMD when it accepts an ordinary command, and from ST_CMD back to ST_IDLE after one cycle. A global reset command moves it from ST_IDLE to ST_RST instead. It stays in ST_RST for a parameter number of cycles and then returns to ST_IDLE. The unit accepts a command only in ST_IDLE. A command's register effects take place on the clock edge that accepts it. The strobes and the busy flag appear in the following cycle.

Top module: `host_cmd_ctrl`

## Requirements
- R1: The opcode is cmd_word[15:11] and the argument is cmd_word[10:0]. For opcodes that take no argument, such as receive enable (0x04), the argument has no effect on the window or the masks.
- R2: Opcode 0x01 loads the window from argument bits 2:0. Higher argument bits are dropped. status_word[15:13] always shows the current window.
- R3: Accepting any command other than global reset sets status_word[12] for exactly one cycle. A command presented while status_word[12] is high is dropped.
- R4: After a global reset command, status_word[12] stays high for RST_CYC consecutive cycles.
- R5: evt_in[k] (k = 1 to 7) latches event bit k. Bit 1 is adapter failure, 2 TX complete, 3 TX available, 4 RX complete, 5 RX early, 6 interrupt requested and 7 statistics update. status_word[7:0] shows the latched bits ANDed with the read mask. Opcode 0x0F loads the read mask from argument bits 7:0. status_word[11:8] reads zero.
- R6: Opcode 0x0D clears each latched bit whose argument bit (7:0) is set and leaves the other bits unchanged.
- R7: If an event pulse and an acknowledge of the same bit arrive in the same cycle, the bit stays set.
- R8: Opcode 0x0C sets latched bit 6.
- R9: Opcode 0x0E loads the interrupt enable mask from argument bits 7:1. irq is high exactly while some latched bit 1 to 7 is set with its enable set.
- R10: Latched bit 0 becomes set on the edge after any cycle in which irq is high. An acknowledge of bit 0 clears it only while irq is low.
- R11: Opcode 0x00 clears all latched bits, the enable mask and the read mask. It selects window 0, turns receive and transmit off, and pulses glob_rst_stb for one cycle.
- R12: Opcodes 0x04/0x03 set and clear rx_on. Opcodes 0x09/0x0A set and clear tx_on. Opcodes 0x05 and 0x0B each pulse rx_rst_stb or tx_rst_stb for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_word | input | 16 | Opcode and argument |
| evt_in | input | 7 | Event pulses for status bits 7:1 |
| status_word | output | 16 | Window, busy flag and masked events |
| irq | output | 1 | Interrupt request |
| rx_on | output | 1 | Receiver enabled level |
| tx_on | output | 1 | Transmitter enabled level |
| rx_rst_stb | output | 1 | Receive reset pulse |
| tx_rst_stb | output | 1 | Transmit reset pulse |
| glob_rst_stb | output | 1 | Global reset pulse |

## Verification
If the sequencer is stuck in the wrong state, status_word[12] shows it at once. The flag stays high too long or drops early, and a command that should have been dropped changes the window one cycle later. An event latch that loses its bit, or that clears on a collided acknowledge, shows up as a missing status bit in the cycle after the edge. Interrupt-latch errors show as bit 0 being late by one edge or clearing while irq is still high. Global-reset faults show as a nonzero window, leftover masks or the wrong number of busy cycles.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
    localparam int OPC_W = 5;
    localparam int ARG_W = 11;
    localparam int CMD_W = OPC_W + ARG_W;
    localparam int EVT_N = 8;
    localparam int WIN_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_GRESET = 5'h00,
        OP_WINSEL = 5'h01,
        OP_RX_OFF = 5'h03,
        OP_RX_ON  = 5'h04,
        OP_RX_RST = 5'h05,
        OP_TX_ON  = 5'h09,
        OP_TX_OFF = 5'h0A,
        OP_TX_RST = 5'h0B,
        OP_REQ    = 5'h0C,
        OP_ACK    = 5'h0D,
        OP_IEN    = 5'h0E,
        OP_RDMASK = 5'h0F
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_RST
    } busy_st_e;

    typedef struct packed {
        logic grst;
        logic win;
        logic rx_off;
        logic rx_on;
        logic rx_rst;
        logic tx_on;
        logic tx_off;
        logic tx_rst;
        logic req;
        logic ack;
        logic ien;
        logic rdm;
    } ctl_t;
endpackage

// File: rtl/hcc_decode.sv
module hcc_decode
    import hcc_pkg::*;
(
    input  logic             accept,
    input  logic [CMD_W-1:0] cmd_word,
    output ctl_t             ctl
);
    logic [OPC_W-1:0] opc;
    assign opc = cmd_word[CMD_W-1:ARG_W];

    always_comb begin
        ctl = '0;
        if (accept) begin
            unique case (opc)
                OP_GRESET: ctl.grst   = 1'b1;
                OP_WINSEL: ctl.win    = 1'b1;
                OP_RX_OFF: ctl.rx_off = 1'b1;
                OP_RX_ON:  ctl.rx_on  = 1'b1;
                OP_RX_RST: ctl.rx_rst = 1'b1;
                OP_TX_ON:  ctl.tx_on  = 1'b1;
                OP_TX_OFF: ctl.tx_off = 1'b1;
                OP_TX_RST: ctl.tx_rst = 1'b1;
                OP_REQ:    ctl.req    = 1'b1;
                OP_ACK:    ctl.ack    = 1'b1;
                OP_IEN:    ctl.ien    = 1'b1;
                OP_RDMASK: ctl.rdm    = 1'b1;
                default:   ctl        = '0;
            endcase
        end
    end
endmodule

// File: rtl/hcc_busy_fsm.sv
module hcc_busy_fsm
    import hcc_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic grst,
    output logic busy
);
    localparam int CNT_W = $clog2(RST_CYC + 1);

    busy_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = grst ? ST_RST : ST_CMD;
            ST_CMD:  state_d = ST_IDLE;
            ST_RST:  if (cnt_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && accept && grst)
                cnt_q <= CNT_W'(RST_CYC - 1);
            else if (state_q == ST_RST && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/hcc_event_bank.sv
module hcc_event_bank
    import hcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [EVT_N-1:1] set_ev,
    input  logic             ack_en,
    input  logic [EVT_N-1:0] ack_bits,
    input  logic [EVT_N-1:1] ien,
    output logic [EVT_N-1:0] lat,
    output logic             irq
);
    assign irq = |(lat[EVT_N-1:1] & ien);

    for (genvar k = 1; k < EVT_N; k++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lat[k] <= 1'b0;
            else if (clr)
                lat[k] <= 1'b0;
            else if (set_ev[k])
                lat[k] <= 1'b1;
            else if (ack_en && ack_bits[k])
                lat[k] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat[0] <= 1'b0;
        else if (clr)
            lat[0] <= 1'b0;
        else if (irq)
            lat[0] <= 1'b1;
        else if (ack_en && ack_bits[0])
            lat[0] <= 1'b0;
    end
endmodule

// File: rtl/host_cmd_ctrl.sv
module host_cmd_ctrl
    import hcc_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [15:0]           cmd_word,
    input  logic [7:1]            evt_in,
    output logic [15:0]           status_word,
    output logic                  irq,
    output logic                  rx_on,
    output logic                  tx_on,
    output logic                  rx_rst_stb,
    output logic                  tx_rst_stb,
    output logic                  glob_rst_stb
);
    localparam int REQ_BIT = 6;

    logic             busy, accept;
    ctl_t             ctl;
    logic [ARG_W-1:0] arg;
    logic [WIN_W-1:0] win_q;
    logic [EVT_N-1:1] ien_q;
    logic [EVT_N-1:0] rdm_q;
    logic [EVT_N-1:0] lat;
    logic [EVT_N-1:1] set_ev;
    logic             unused_arg;

    assign accept     = cmd_valid & ~busy;
    assign arg        = cmd_word[ARG_W-1:0];
    assign unused_arg = ^arg[ARG_W-1:EVT_N];

    hcc_decode u_dec (
        .accept   (accept),
        .cmd_word (cmd_word),
        .ctl      (ctl)
    );

    hcc_busy_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .grst   (ctl.grst),
        .busy   (busy)
    );

    always_comb begin
        set_ev          = evt_in;
        set_ev[REQ_BIT] = evt_in[REQ_BIT] | ctl.req;
    end

    hcc_event_bank u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl.grst),
        .set_ev   (set_ev),
        .ack_en   (ctl.ack),
        .ack_bits (arg[EVT_N-1:0]),
        .ien      (ien_q),
        .lat      (lat),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q        <= '0;
            ien_q        <= '0;
            rdm_q        <= '0;
            rx_on        <= 1'b0;
            tx_on        <= 1'b0;
            rx_rst_stb   <= 1'b0;
            tx_rst_stb   <= 1'b0;
            glob_rst_stb <= 1'b0;
        end else begin
            rx_rst_stb   <= ctl.rx_rst;
            tx_rst_stb   <= ctl.tx_rst;
            glob_rst_stb <= ctl.grst;
            if (ctl.grst) begin
                win_q <= '0;
                ien_q <= '0;
                rdm_q <= '0;
                rx_on <= 1'b0;
                tx_on <= 1'b0;
            end else begin
                if (ctl.win)    win_q <= arg[WIN_W-1:0];
                if (ctl.ien)    ien_q <= arg[EVT_N-1:1];
                if (ctl.rdm)    rdm_q <= arg[EVT_N-1:0];
                if (ctl.rx_on)  rx_on <= 1'b1;
                if (ctl.rx_off) rx_on <= 1'b0;
                if (ctl.tx_on)  tx_on <= 1'b1;
                if (ctl.tx_off) tx_on <= 1'b0;
            end
        end
    end

    assign status_word = {win_q, busy, 4'b0000, lat & rdm_q};
endmodule

// File: rtl/hcc_checker.sv
module hcc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic [7:1]  evt_in,
    input logic [15:0] status_word,
    input logic        irq,
    input logic        rx_on,
    input logic        glob_rst_stb,
    input logic [7:0]  lat
);
    logic acc, grst_acc;
    assign acc      = cmd_valid && !status_word[12];
    assign grst_acc = acc && (cmd_word[15:11] == 5'h00);

    p_busy_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> status_word[12]);

    p_window_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && (cmd_word[15:11] == 5'h00 || cmd_word[15:11] == 5'h01))
        |=> $stable(status_word[15:13]));

    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!grst_acc && evt_in != 7'd0)
        |=> ((lat[7:1] & $past(evt_in)) == $past(evt_in)));

    p_irq_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !grst_acc) |=> lat[0]);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (lat[7:1] != 7'd0));

    p_global_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        grst_acc |=> (status_word[15:13] == 3'd0 && lat == 8'd0 && !rx_on && glob_rst_stb));

    p_reset_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rst_stb |-> status_word[12]);
endmodule

bind host_cmd_ctrl hcc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .evt_in       (evt_in),
    .status_word  (status_word),
    .irq          (irq),
    .rx_on        (rx_on),
    .glob_rst_stb (glob_rst_stb),
    .lat          (lat)
);

// File: tb/host_cmd_ctrl_bench.sv
module host_cmd_ctrl_bench;
    localparam int RST_CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [7:1]  evt_in = '0;
    logic [15:0] status_word;
    logic        irq, rx_on, tx_on, rx_rst_stb, tx_rst_stb, glob_rst_stb;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    host_cmd_ctrl #(.RST_CYC(RST_CYC)) u_host_cmd_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_word     (cmd_word),
        .evt_in       (evt_in),
        .status_word  (status_word),
        .irq          (irq),
        .rx_on        (rx_on),
        .tx_on        (tx_on),
        .rx_rst_stb   (rx_rst_stb),
        .tx_rst_stb   (tx_rst_stb),
        .glob_rst_stb (glob_rst_stb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            report();
        end
    end

    task automatic issue(input logic [15:0] w);
        while (status_word[12]) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] m);
        evt_in = m[7:1];
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic t_reset();
        check("R11 reset status", status_word, 16'h0000);
        check("R11 reset irq", irq, 0);
        check("R11 reset rx_on", rx_on, 0);
    endtask

    task automatic t_window();
        issue(16'h0800 | 16'd5);
        check("R2 window", status_word[15:13], 5);
        check("R3 busy one", status_word[12], 1);
        settle();
        check("R3 busy cleared", status_word[12], 0);
        issue(16'h0800 | 11'h7FA);
        settle();
        check("R2 upper arg bits dropped", status_word[15:13], 2);
    endtask

    task automatic t_arg_ignored();
        issue(16'h2000 | 11'h7FF);
        settle();
        check("R1 rx_on set", rx_on, 1);
        check("R1 window untouched", status_word[15:13], 2);
        pulse(8'h10);
        check("R1 masks untouched status", status_word[7:0], 8'h00);
        check("R1 masks untouched irq", irq, 0);
        issue(16'h6810);
        settle();
    endtask

    task automatic t_busy_ignore();
        issue(16'h0800 | 16'd3);
        cmd_valid = 1'b1;
        cmd_word  = 16'h0800 | 16'd6;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
        settle();
        check("R3 cmd during busy dropped", status_word[15:13], 3);
    endtask

    task automatic t_events_irq();
        issue(16'h78FF);
        issue(16'h7010);
        settle();
        pulse(8'h04);
        check("R5 tx complete latched", status_word[7:0], 8'h04);
        check("R9 disabled bit no irq", irq, 0);
        pulse(8'h10);
        check("R5 rx complete latched", status_word[7:0], 8'h14);
        check("R9 enabled bit irq", irq, 1);
        settle();
        check("R10 latch bit follows irq", status_word[7:0], 8'h15);
        issue(16'h6801);
        settle();
        check("R10 ack bit0 ignored while irq", status_word[0], 1);
        issue(16'h6810);
        check("R6 ack clears bit4 only", status_word[7:0], 8'h05);
        check("R9 irq drops", irq, 0);
        settle();
        issue(16'h6801);
        check("R10 ack bit0 clears", status_word[7:0], 8'h04);
        check("R5 reserved bits zero", status_word[11:8], 0);
    endtask

    task automatic t_collision();
        settle();
        cmd_valid = 1'b1;
        cmd_word  = 16'h6804;
        evt_in    = 7'b0000010;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
        evt_in    = '0;
        check("R7 event beats ack", status_word[2], 1);
        issue(16'h6804);
        check("R6 lone ack clears", status_word[7:0], 8'h00);
    endtask

    task automatic t_request();
        issue(16'h6000);
        check("R8 request sets bit6", status_word[7:0], 8'h40);
        check("R8 bit6 not enabled", irq, 0);
        issue(16'h7040);
        check("R9 bit6 enabled irq", irq, 1);
        issue(16'h7800);
        check("R5 read mask hides", status_word[7:0], 8'h00);
        check("R5 irq independent of read mask", irq, 1);
        issue(16'h78FF);
    endtask

    task automatic t_paths();
        issue(16'h4800);
        check("R12 tx on", tx_on, 1);
        issue(16'h2800);
        check("R12 rx reset pulse", rx_rst_stb, 1);
        settle();
        check("R12 rx reset pulse ends", rx_rst_stb, 0);
        issue(16'h5800);
        check("R12 tx reset pulse", tx_rst_stb, 1);
        issue(16'h5000);
        check("R12 tx off", tx_on, 0);
        issue(16'h2000);
        issue(16'h1800);
        check("R12 rx off", rx_on, 0);
        issue(16'h2000);
        issue(16'h4800);
    endtask

    task automatic t_global_reset();
        int busy_n;
        issue(16'h0800 | 16'd4);
        issue(16'h0000);
        check("R11 strobe", glob_rst_stb, 1);
        check("R11 window zero", status_word[15:13], 0);
        check("R11 irq cleared", irq, 0);
        check("R11 rx off", rx_on, 0);
        check("R11 tx off", tx_on, 0);
        busy_n = 0;
        while (status_word[12]) begin
            busy_n++;
            @(negedge clk);
        end
        check("R4 reset busy length", busy_n, RST_CYC);
        check("R11 strobe ends", glob_rst_stb, 0);
        issue(16'h78FF);
        settle();
        check("R11 latches cleared", status_word[7:0], 8'h00);
        pulse(8'h10);
        check("R11 enable mask cleared", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_arg_ignored();
        t_busy_ignore();
        t_events_irq();
        t_collision();
        t_request();
        t_paths();
        t_global_reset();
        report();
    end
endmodule